// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative table of segment descriptors. Each entry keeps an effective segment identifier with a valid flag, together with a descriptor word that carries the virtual segment identifier, a segment-size code, a class bit, protection key bits and a base page-size code. A lookup port compares the upper effective-address bits against every entry at once. Each entry matches at 256 MB or at 1 TB granularity, as its own size code selects. The port returns hit, the index of the matching entry and its descriptor word in the same cycle.

A one-cycle command port performs the table maintenance operations. These are: store an entry, read back either word of an entry, find a descriptor by address, invalidate by address, and invalidate all under a hint code. Every command answers one cycle later with a response strobe, an error flag and a data word. Invalidations also raise a local or global request to flush the downstream translation cache. An illegal command returns an error and leaves the table untouched. The walk of an in-memory segment table and the translation cache itself lie outside this block.

Top module: `slb_array`

## Requirements
- R1: After reset every entry is invalid with both words zero; lookups miss, and rsp_valid, rsp_err, flush_local, flush_global and hint_warn are low.
- R2: An entry whose size code (descriptor bits 63:62) is 0 hits when it is valid and its stored identifier equals effective-address bits 63:28.
- R3: An entry whose size code is 1 hits when it is valid and its stored identifier equals effective-address bits 63:40 followed by twelve zero bits.
- R4: When several entries hit, the lowest index wins, on both the lookup port and the address-based commands.
- R5: Store (op 0) writes the slot given by cmd_rb[11:0]. The identifier comes from cmd_rb[63:28], the valid flag from cmd_rb[27] and the descriptor from cmd_rs. Read-identifier (op 1) returns {identifier, valid, 27 zero bits}. Read-descriptor (op 2) returns the descriptor. A read of a slot at or beyond the depth returns an error.
- R6: Store returns an error and changes nothing in any of these cases: the slot is at or beyond the depth; cmd_rb[26:12] is not zero; the size code is 2 or 3; the size code is 1 while seg1t_en is low; or the page-size code {descriptor bit 8, bits 5:4} is not enabled in the PSZ_OK mask.
- R7: Find (op 3) returns the descriptor of the winning entry for cmd_rb, or all ones on a miss. Find returns an error when mode64 is low.
- R8: Invalidate-by-address (op 4) clears the valid flag of the winning entry for cmd_rb. Only when it clears an entry does it pulse flush_global if cmd_global is 1, or flush_local otherwise.
- R9: Invalidate-all (op 5) with hint 0, 1, 2 or 6, or with any hint while new_arch is low, clears every entry except entry 0. Every invalidate-all pulses flush_local.
- R10: While new_arch is high, hint 3 also spares entries whose class bit (descriptor bit 7) is 0. Hint 4 clears entry 0 as well. Hint 7 clears nothing.
- R11: While new_arch is high, hint 5 acts as hint 0 and pulses hint_warn; hint_warn never pulses otherwise.
- R12: Responses and flush pulses appear exactly one cycle after the command; lookups reflect the table as written by the previous edge; ops 6 and 7 return an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_arch | input | 1 | Enables the extended invalidate-all hint codes |
| seg1t_en | input | 1 | Allows 1 TB segments to be stored |
| mode64 | input | 1 | Core is in 64-bit mode; find is legal only then |
| lk_seg | input | 36 | Effective-address bits 63:28 to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_idx | output | 5 | Index of the winning entry |
| lk_vsid | output | 64 | Descriptor of the winning entry, zero on a miss |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_rb | input | 64 | Address or slot operand |
| cmd_rs | input | 64 | Descriptor operand for store |
| cmd_ih | input | 3 | Invalidate-all hint |
| cmd_global | input | 1 | Invalidate-by-address requests a global flush |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Command was illegal |
| rsp_data | output | 64 | Read or find result |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |
| hint_warn | output | 1 | Undefined invalidate-all hint seen |

## Verification
A wrong valid flag or identifier shows at the lookup port in the very next cycle as a missed or extra hit. It also shows as a wrong valid bit in a read-identifier response one cycle after the read. A bad priority choice shows as a wrong index or descriptor when two entries share a segment. A rejected store that still wrote the table, or an invalidate that cleared the wrong set of entries, is caught by reading the affected slots back or by probing their segments on the lookup port. A missing or misrouted flush is visible on the cycle that follows the command.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned EA_W     = 64;
  localparam int unsigned SEG_LSB  = 28;              // 256 MB granularity
  localparam int unsigned TSEG_LSB = 40;              // 1 TB granularity
  localparam int unsigned ESID_W   = EA_W - SEG_LSB;  // 36
  localparam int unsigned TLOW_W   = TSEG_LSB - SEG_LSB;
  localparam int unsigned SLOT_W   = 12;
  localparam int unsigned VBIT     = 27;
  localparam int unsigned SZ_LSB   = 62;
  localparam int unsigned CLS_BIT  = 7;
  localparam int unsigned LRG_BIT  = 8;
  localparam int unsigned LP_LSB   = 4;

  localparam logic [1:0] SZ_256M = 2'd0;
  localparam logic [1:0] SZ_1T   = 2'd1;

  typedef enum logic [2:0] {
    OP_STORE    = 3'd0,
    OP_RD_ESID  = 3'd1,
    OP_RD_VSID  = 3'd2,
    OP_FIND     = 3'd3,
    OP_INV_ADDR = 3'd4,
    OP_INV_ALL  = 3'd5
  } slb_op_e;
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [ESID_W-1:0]         seg,
  input  logic [N-1:0]              ent_v,
  input  logic [N-1:0][ESID_W-1:0]  ent_id,
  input  logic [N-1:0][1:0]         ent_sz,
  output logic [N-1:0]              mvec,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx
);
  logic [ESID_W-1:0] seg_1t;
  assign seg_1t = {seg[ESID_W-1:TLOW_W], {TLOW_W{1'b0}}};

  // R2 R3: per-entry compare at the granularity the entry selects
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign mvec[i] = ent_v[i] &&
                     (((ent_sz[i] == SZ_256M) && (ent_id[i] == seg)) ||
                      ((ent_sz[i] == SZ_1T)   && (ent_id[i] == seg_1t)));
  end

  // R4: lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mvec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slb_store_chk.sv
module slb_store_chk
  import slb_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter logic [7:0]  PSZ_OK = 8'hB1
) (
  input  logic [SLOT_W-1:0]      slot,
  input  logic [VBIT-1:SLOT_W]   rsvd,
  input  logic [1:0]             size,
  input  logic [2:0]             psz,
  input  logic                   seg1t_en,
  output logic                   slot_ok,
  output logic                   store_ok
);
  localparam logic [SLOT_W:0] NSLOT = (SLOT_W + 1)'(N);

  logic rsvd_bad, size_bad, tseg_bad, psz_bad;

  assign slot_ok  = ({1'b0, slot} < NSLOT);
  assign rsvd_bad = |rsvd;
  assign size_bad = size[1];
  assign tseg_bad = (size == SZ_1T) && !seg1t_en;
  assign psz_bad  = !PSZ_OK[psz];
  // R6: any single violation rejects the store
  assign store_ok = slot_ok && !rsvd_bad && !size_bad && !tseg_bad && !psz_bad;
endmodule

// File: rtl/slb_inv_sel.sv
module slb_inv_sel #(
  parameter int unsigned N = 32
) (
  input  logic [2:0]   hint,
  input  logic         new_arch,
  input  logic [N-1:0] ent_v,
  input  logic [N-1:0] ent_cls,
  output logic [N-1:0] clr,
  output logic         warn
);
  logic keep_none, incl_zero, spare_c0;

  // R10 R11: extended hint codes only in the newer mode
  assign keep_none = new_arch && (hint == 3'd7);
  assign incl_zero = new_arch && (hint == 3'd4);
  assign spare_c0  = new_arch && (hint == 3'd3);
  assign warn      = new_arch && (hint == 3'd5);

  for (genvar i = 0; i < N; i++) begin : g_clr
    if (i == 0) begin : g_first
      assign clr[i] = ent_v[i] && incl_zero;
    end else begin : g_rest
      assign clr[i] = ent_v[i] && !keep_none && !(spare_c0 && !ent_cls[i]);
    end
  end
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter logic [7:0]  PSZ_OK = 8'hB1,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               new_arch,
  input  logic               seg1t_en,
  input  logic               mode64,
  input  logic [ESID_W-1:0]  lk_seg,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [EA_W-1:0]    lk_vsid,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [EA_W-1:0]    cmd_rb,
  input  logic [EA_W-1:0]    cmd_rs,
  input  logic [2:0]         cmd_ih,
  input  logic               cmd_global,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [EA_W-1:0]    rsp_data,
  output logic               flush_local,
  output logic               flush_global,
  output logic               hint_warn
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // table state
  logic [N-1:0]             valid_q, valid_d;
  logic [N-1:0][ESID_W-1:0] esid_q,  esid_d;
  logic [N-1:0][EA_W-1:0]   vsid_q,  vsid_d;
  logic [N-1:0][1:0]        size_vec;
  logic [N-1:0]             cls_vec;

  for (genvar i = 0; i < N; i++) begin : g_fld
    assign size_vec[i] = vsid_q[i][SZ_LSB+1:SZ_LSB];
    assign cls_vec[i]  = vsid_q[i][CLS_BIT];
  end

  // lookup port (R2 R3 R4)
  logic [N-1:0] lk_mvec;

  slb_match #(.N(N), .IDX_W(IDX_W)) u_lk_match (
    .seg    (lk_seg),
    .ent_v  (valid_q),
    .ent_id (esid_q),
    .ent_sz (size_vec),
    .mvec   (lk_mvec),
    .hit    (lk_hit),
    .idx    (lk_idx)
  );
  assign lk_vsid = lk_hit ? vsid_q[lk_idx] : '0;

  // command-side address match (R7 R8)
  logic [N-1:0]     cm_mvec;
  logic             cm_hit;
  logic [IDX_W-1:0] cm_idx;

  slb_match #(.N(N), .IDX_W(IDX_W)) u_cmd_match (
    .seg    (cmd_rb[EA_W-1:SEG_LSB]),
    .ent_v  (valid_q),
    .ent_id (esid_q),
    .ent_sz (size_vec),
    .mvec   (cm_mvec),
    .hit    (cm_hit),
    .idx    (cm_idx)
  );

  // store legality (R5 R6)
  logic slot_ok, store_ok;

  slb_store_chk #(.N(N), .PSZ_OK(PSZ_OK)) u_chk (
    .slot     (cmd_rb[SLOT_W-1:0]),
    .rsvd     (cmd_rb[VBIT-1:SLOT_W]),
    .size     (cmd_rs[SZ_LSB+1:SZ_LSB]),
    .psz      ({cmd_rs[LRG_BIT], cmd_rs[LP_LSB+1:LP_LSB]}),
    .seg1t_en (seg1t_en),
    .slot_ok  (slot_ok),
    .store_ok (store_ok)
  );

  // invalidate-all selection (R9 R10 R11)
  logic [N-1:0] inv_clr;
  logic         inv_warn;

  slb_inv_sel #(.N(N)) u_inv (
    .hint     (cmd_ih),
    .new_arch (new_arch),
    .ent_v    (valid_q),
    .ent_cls  (cls_vec),
    .clr      (inv_clr),
    .warn     (inv_warn)
  );

  // next state and response
  logic [IDX_W-1:0] slot_idx;
  logic             arr_en;
  logic             rsp_err_d, fl_d, fg_d, warn_d;
  logic [EA_W-1:0]  rsp_data_d;

  assign slot_idx = cmd_rb[IDX_W-1:0];
  assign arr_en   = cmd_valid;

  always_comb begin
    valid_d    = valid_q;
    esid_d     = esid_q;
    vsid_d     = vsid_q;
    rsp_err_d  = 1'b0;
    rsp_data_d = '0;
    fl_d       = 1'b0;
    fg_d       = 1'b0;
    warn_d     = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_STORE: begin
          if (store_ok) begin
            valid_d[slot_idx] = cmd_rb[VBIT];
            esid_d[slot_idx]  = cmd_rb[EA_W-1:SEG_LSB];
            vsid_d[slot_idx]  = cmd_rs;
          end else begin
            rsp_err_d = 1'b1;
          end
        end
        OP_RD_ESID: begin
          if (slot_ok) rsp_data_d = {esid_q[slot_idx], valid_q[slot_idx], {VBIT{1'b0}}};
          else         rsp_err_d  = 1'b1;
        end
        OP_RD_VSID: begin
          if (slot_ok) rsp_data_d = vsid_q[slot_idx];
          else         rsp_err_d  = 1'b1;
        end
        OP_FIND: begin
          if (!mode64)     rsp_err_d  = 1'b1;
          else if (cm_hit) rsp_data_d = vsid_q[cm_idx];
          else             rsp_data_d = '1;
        end
        OP_INV_ADDR: begin
          if (cm_hit) begin
            valid_d[cm_idx] = 1'b0;
            fg_d = cmd_global;
            fl_d = !cmd_global;
          end
        end
        OP_INV_ALL: begin
          valid_d = valid_q & ~inv_clr;
          fl_d    = 1'b1;
          warn_d  = inv_warn;
        end
        default: rsp_err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= '0;
      esid_q  <= '0;
      vsid_q  <= '0;
    end else if (arr_en) begin
      valid_q <= valid_d;
      esid_q  <= esid_d;
      vsid_q  <= vsid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_data     <= '0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
      hint_warn    <= 1'b0;
    end else begin
      rsp_valid    <= cmd_valid;
      rsp_err      <= rsp_err_d;
      rsp_data     <= rsp_data_d;
      flush_local  <= fl_d;
      flush_global <= fg_d;
      hint_warn    <= warn_d;
    end
  end

  // assertions
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_err) |-> (valid_q == $past(valid_q)) && (esid_q == $past(esid_q))) else $error("error response changed table"); // R6

  AST_FIND_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && (cmd_op == OP_FIND) && !mode64) |=> (rsp_valid && rsp_err)) else $error("find outside 64-bit mode accepted"); // R7

  AST_GLOBAL_SRC: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush_global |-> $past(cmd_valid && (cmd_op == OP_INV_ADDR) && cmd_global)) else $error("stray global flush"); // R8

  AST_INVALL_FLUSH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && (cmd_op == OP_INV_ALL)) |=> flush_local) else $error("invalidate-all without flush"); // R9

  AST_ENTRY0_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && (cmd_op == OP_INV_ALL) && !(new_arch && (cmd_ih == 3'd4))) |=> (valid_q[0] == $past(valid_q[0]))) else $error("entry 0 lost"); // R9

  AST_WARN_SRC: assert property (@(posedge clk) disable iff (!rst_int_n)
    hint_warn |-> $past(cmd_valid && (cmd_op == OP_INV_ALL) && new_arch && (cmd_ih == 3'd5))) else $error("stray hint warning"); // R11

  AST_LK_LOWEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_hit |-> (lk_mvec[lk_idx] && ((lk_mvec & ((N'(1) << lk_idx) - N'(1))) == '0))) else $error("lookup did not pick lowest match"); // R4

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_valid |=> rsp_valid) else $error("response missing"); // R12
endmodule

// File: tb/slb_array_test.sv
`timescale 1ns/1ps
module slb_array_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        new_arch, seg1t_en, mode64;
  logic [35:0] lk_seg;
  logic        lk_hit;
  logic [4:0]  lk_idx;
  logic [63:0] lk_vsid;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [63:0] cmd_rb, cmd_rs;
  logic [2:0]  cmd_ih;
  logic        cmd_global;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_data;
  logic        flush_local, flush_global, hint_warn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  slb_array #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .new_arch(new_arch), .seg1t_en(seg1t_en), .mode64(mode64),
    .lk_seg(lk_seg), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rb(cmd_rb), .cmd_rs(cmd_rs),
    .cmd_ih(cmd_ih), .cmd_global(cmd_global),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .flush_local(flush_local), .flush_global(flush_global), .hint_warn(hint_warn)
  );

  function automatic logic [63:0] rbw(input logic [35:0] e, input logic v, input logic [11:0] s);
    return {e, v, 15'd0, s};
  endfunction
  function automatic logic [63:0] esw(input logic [35:0] e, input logic v);
    return {e, v, 27'd0};
  endfunction

  localparam logic [35:0] EA = 36'h000000123;
  localparam logic [35:0] EB = 36'h000000456;
  localparam logic [35:0] EC = 36'h00000A000;
  localparam logic [35:0] ED = 36'h000000777;
  localparam logic [35:0] EP = 36'h0000000AB;
  localparam logic [63:0] VA = 64'h0000_0000_0ABC_D000;
  localparam logic [63:0] VB = 64'h0000_0000_0BCD_E080;
  localparam logic [63:0] VC = 64'h4000_0000_0CDE_F180;
  localparam logic [63:0] VD = 64'h0000_0000_0DDD_D000;
  localparam logic [63:0] V2 = 64'h0000_0000_0000_1000;
  localparam logic [63:0] V9 = 64'h0000_0000_0000_2000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] rb;
    logic [63:0] rs;
    logic [2:0]  ih;
    logic        glb;
    logic        err;
    logic        chk;
    logic [63:0] dat;
    logic        fl;
    logic        fg;
    logic        wr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{3'd0, rbw(EA,1,0),  VA, 3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 store 256M
    '{3'd0, rbw(EB,1,3),  VB, 3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd0, rbw(EC,1,5),  VC, 3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 store 1T
    '{3'd1, rbw(0,0,3),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EB,1), 1'b0, 1'b0, 1'b0, 4'd5}, // R5 read id
    '{3'd2, rbw(0,0,5),   0,  3'd0, 1'b0, 1'b0, 1'b1, VC, 1'b0, 1'b0, 1'b0, 4'd5},     // R5 read descriptor
    '{3'd3, {EB,28'h0123456}, 0, 3'd0, 1'b0, 1'b0, 1'b1, VB, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 find
    '{3'd3, {24'h00000A,40'h1234567890}, 0, 3'd0, 1'b0, 1'b0, 1'b1, VC, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
    '{3'd3, {36'h999,28'h0}, 0, 3'd0, 1'b0, 1'b0, 1'b1, ONES, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 miss
    '{3'd0, rbw(ED,1,32), VD, 3'd0, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 slot range
    '{3'd0, rbw(ED,1,1) | 64'h1000, VD, 3'd0, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 reserved
    '{3'd0, rbw(ED,1,1),  64'h8000_0000_0000_0000, 3'd0, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 size
    '{3'd0, rbw(ED,1,1),  64'h10, 3'd0, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 page size
    '{3'd1, rbw(0,0,1),   0,  3'd0, 1'b0, 1'b0, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 unchanged
    '{3'd2, rbw(0,0,40),  0,  3'd0, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 read range
    '{3'd4, {EB,28'h5},   0,  3'd0, 1'b1, 1'b0, 1'b0, 64'd0, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 global
    '{3'd4, {EB,28'h5},   0,  3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 no clear
    '{3'd1, rbw(0,0,3),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EB,0), 1'b0, 1'b0, 1'b0, 4'd8}, // R8
    '{3'd0, rbw(EB,1,3),  VB, 3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{3'd0, rbw(ED,1,7),  VD, 3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{3'd5, 64'd0, 0, 3'd3, 1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 4'd10},          // R10 hint 3
    '{3'd1, rbw(0,0,7),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(ED,1), 1'b0, 1'b0, 1'b0, 4'd10},
    '{3'd1, rbw(0,0,3),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EB,0), 1'b0, 1'b0, 1'b0, 4'd10},
    '{3'd1, rbw(0,0,5),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EC,0), 1'b0, 1'b0, 1'b0, 4'd10},
    '{3'd5, 64'd0, 0, 3'd5, 1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b1, 4'd11},          // R11 hint 5
    '{3'd1, rbw(0,0,7),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(ED,0), 1'b0, 1'b0, 1'b0, 4'd11},
    '{3'd1, rbw(0,0,0),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EA,1), 1'b0, 1'b0, 1'b0, 4'd11},
    '{3'd5, 64'd0, 0, 3'd7, 1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 4'd10},          // R10 hint 7
    '{3'd1, rbw(0,0,0),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EA,1), 1'b0, 1'b0, 1'b0, 4'd10},
    '{3'd5, 64'd0, 0, 3'd4, 1'b0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 4'd10},          // R10 hint 4
    '{3'd1, rbw(0,0,0),   0,  3'd0, 1'b0, 1'b0, 1'b1, esw(EA,0), 1'b0, 1'b0, 1'b0, 4'd10},
    '{3'd4, {EA,28'h0},   0,  3'd0, 1'b0, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 invalid entry
    '{3'd6, 64'd0, 0, 3'd0, 1'b0, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 4'd12}           // R12 bad op
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge; returns at the next falling edge with the response visible
  task automatic issue(input logic [2:0] op, input logic [63:0] rb, input logic [63:0] rs,
                       input logic [2:0] ih, input logic g);
    cmd_valid = 1'b1; cmd_op = op; cmd_rb = rb; cmd_rs = rs; cmd_ih = ih; cmd_global = g;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic look(input logic [35:0] s, input logic eh, input logic [4:0] ei,
                      input logic [63:0] ev, input string req);
    lk_seg = s;
    #1;
    chk((lk_hit === eh) && (!eh || (lk_idx === ei)) && (lk_vsid === ev), req,
        {lk_hit, 58'd0, lk_idx} ^ lk_vsid, {eh, 58'd0, ei} ^ ev);
  endtask

  task automatic resp(input logic e, input logic fl, input logic fg, input logic w, input string req);
    chk(rsp_valid && (rsp_err === e) && (flush_local === fl) && (flush_global === fg) && (hint_warn === w),
        req, {60'd0, rsp_err, flush_local, flush_global, hint_warn}, {60'd0, e, fl, fg, w});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; new_arch = 1'b1; seg1t_en = 1'b1; mode64 = 1'b1;
    lk_seg = '0; cmd_valid = 1'b0; cmd_op = '0; cmd_rb = '0; cmd_rs = '0; cmd_ih = '0; cmd_global = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(!rsp_valid && !rsp_err && !flush_local && !flush_global && !hint_warn, "R1 outputs",
        {59'd0, rsp_valid, rsp_err, flush_local, flush_global, hint_warn}, 64'd0);
    look(EA, 1'b0, 5'd0, 64'd0, "R1 lookup");
    issue(3'd1, rbw(0,0,0), 64'd0, 3'd0, 1'b0);
    chk(!rsp_err && (rsp_data === 64'd0), "R1 entry 0", rsp_data, 64'd0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].op, VEC[k].rb, VEC[k].rs, VEC[k].ih, VEC[k].glb);
      checks++;
      if (!(rsp_valid && (rsp_err === VEC[k].err) && (flush_local === VEC[k].fl) &&
            (flush_global === VEC[k].fg) && (hint_warn === VEC[k].wr) &&
            (!VEC[k].chk || (rsp_data === VEC[k].dat)))) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual err%b fl%b fg%b w%b %h expected err%b fl%b fg%b w%b %h",
                 VEC[k].req, k, rsp_err, flush_local, flush_global, hint_warn, rsp_data,
                 VEC[k].err, VEC[k].fl, VEC[k].fg, VEC[k].wr, VEC[k].dat);
      end
    end

    // R4 R12: two entries on one segment, visible on the next cycle
    issue(3'd0, rbw(EP,1,9), V9, 3'd0, 1'b0);
    issue(3'd0, rbw(EP,1,2), V2, 3'd0, 1'b0);
    look({EP}, 1'b1, 5'd2, V2, "R4 lowest index");
    issue(3'd4, {EP,28'h0}, 64'd0, 3'd0, 1'b0);
    resp(1'b0, 1'b1, 1'b0, 1'b0, "R8 local flush");
    look(EP, 1'b1, 5'd9, V9, "R4 next match");
    look({EP[35:12], 12'h0}, 1'b0, 5'd0, 64'd0, "R2 no 1T alias");

    // R9: hint 0 keeps entry 0 only
    issue(3'd0, rbw(EA,1,0), VA, 3'd0, 1'b0);
    issue(3'd5, 64'd0, 64'd0, 3'd0, 1'b0);
    resp(1'b0, 1'b1, 1'b0, 1'b0, "R9 hint 0 flush");
    look(EP, 1'b0, 5'd0, 64'd0, "R9 cleared");
    look(EA, 1'b1, 5'd0, VA, "R9 entry 0 kept");

    // R7: find outside 64-bit mode
    mode64 = 1'b0;
    issue(3'd3, {EA,28'h0}, 64'd0, 3'd0, 1'b0);
    resp(1'b1, 1'b0, 1'b0, 1'b0, "R7 mode");
    mode64 = 1'b1;

    // R6: 1T store with 1T disabled
    seg1t_en = 1'b0;
    issue(3'd0, rbw(EC,1,5), VC, 3'd0, 1'b0);
    resp(1'b1, 1'b0, 1'b0, 1'b0, "R6 1T disabled");
    seg1t_en = 1'b1;
    look(EC, 1'b0, 5'd0, 64'd0, "R6 no write");

    // R9 R11: legacy mode ignores extended hints
    new_arch = 1'b0;
    issue(3'd5, 64'd0, 64'd0, 3'd4, 1'b0);
    resp(1'b0, 1'b1, 1'b0, 1'b0, "R9 legacy hint 4");
    look(EA, 1'b1, 5'd0, VA, "R9 legacy entry 0");
    issue(3'd0, rbw(ED,1,7), VD, 3'd0, 1'b0);
    issue(3'd5, 64'd0, 64'd0, 3'd5, 1'b0);
    resp(1'b0, 1'b1, 1'b0, 1'b0, "R11 legacy no warn");
    look(ED, 1'b0, 5'd0, 64'd0, "R9 legacy cleared");
    new_arch = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule